// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block runs one SPI exchange of whole bytes as a controller. Software loads two byte counts, the whole exchange length and how many of those bytes come from the transmit FIFO. It then writes the control word with the go bit set. The engine shifts each byte out on `mosi` and captures `miso` into the receive FIFO. Any of the four polarity and phase combinations can be used, with either bit order. Bytes owed beyond the transmit-sourced count go out as zero. When the last byte is done the engine drops its go bit and raises a sticky completion flag, which can also drive an interrupt.

Serial clock timing comes from outside. A separate divider supplies `sck_tick`, a one-cycle strobe that marks each half period of SCK. Register address decoding and chip-select generation sit outside this block. The control, status and count values arrive here as already-decoded words and strobes. Both FIFOs hold 64 bytes. Their fill levels are packed into a single status word.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset both FIFO levels read 0, `ctrl_q`, `sts_q` and `irq` read 0, and `sck` sits low.
- R2: Writing `ctrl_wdata` bit 10 (go) while idle latches `burst_len` and `tx_len` and starts the exchange. Bit 10 of `ctrl_q` reads 1 until the last byte finishes, then clears in the same cycle that status bit 16 sets. A go write while bit 10 already reads 1 changes no count and causes no extra bytes.
- R3: Exactly `burst_len` bytes are exchanged. The first `tx_len` of them are popped from the transmit FIFO in order, and the rest are sent as 0x00.
- R4: Control bit 3 (polarity) sets the idle level of `sck`. With control bit 2 (phase) at 0, data is valid before the leading edge and is sampled on it. With phase at 1, data changes on the leading edge and is sampled on the trailing edge. Each byte is 8 bits, which is 16 `sck_tick` strobes.
- R5: With control bit 6 set, bits go out and are assembled least significant first. Otherwise the most significant bit comes first.
- R6: With control bit 15 set, received bytes are dropped and the receive FIFO stays empty. With it clear, every received byte is pushed.
- R7: Each FIFO holds 64 bytes. `fifo_level` bits 6:0 give the receive level and bits 22:16 the transmit level. A push into a full FIFO is dropped.
- R8: A control write with bit 8 empties the transmit FIFO, and one with bit 9 empties the receive FIFO. Neither bit is stored.
- R9: Status bit 16 stays set until a status write with bit 16 at 1. `irq` is high one cycle after both the flag and `tc_irq_en` are high.
- R10: Bytes shift only while control bits 0 (enable) and 1 (controller mode) are both set. A pending exchange waits with `sck` idle and resumes when both are set.
- R11: When transmit-sourced bytes are still owed and the transmit FIFO is empty, the engine stalls between bytes with `sck` idle until data is pushed.
- R12: A go with `burst_len` of 0 completes without any `sck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_q | output | 16 | Control word readback, go bit self-clearing |
| burst_len | input | 24 | Total bytes in the exchange, taken at go |
| tx_len | input | 24 | Bytes sourced from the transmit FIFO, taken at go |
| tc_irq_en | input | 1 | Completion interrupt enable |
| sts_we | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 32 | Status write data |
| sts_q | output | 32 | Status word, completion flag at bit 16 |
| irq | output | 1 | Registered interrupt |
| tx_push | input | 1 | Push a byte into the transmit FIFO |
| tx_byte | input | 8 | Transmit FIFO write data |
| rx_pop | input | 1 | Pop a byte from the receive FIFO |
| rx_byte | output | 8 | Head of the receive FIFO |
| fifo_level | output | 32 | Receive level at 6:0, transmit level at 22:16 |
| sck_tick | input | 1 | Half-period strobe from the clock divider |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bound checker watches four things on every cycle:
- the go bit never falls unless the completion flag is up;
- `sck` rests at the programmed polarity whenever no byte is in flight;
- neither FIFO level passes its depth, and the receive level never rises in discard mode;
- `irq` only follows a gated flag, and `sck` holds still while the engine is disabled.

Other behaviour is visible only through the directed scenarios:
- bit order and phase on the wire;
- zero padding after the transmit-sourced bytes;
- the stall on an empty transmit FIFO;
- the rejected go during an exchange.

The bench checks these with a wire monitor and an inverting loopback on `miso`.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_MST   = 1;
  localparam int CB_CPHA  = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_LSB   = 6;
  localparam int CB_TXRST = 8;
  localparam int CB_RXRST = 9;
  localparam int CB_GO    = 10;
  localparam int CB_DROP  = 15;
  // status word bit
  localparam int SB_DONE  = 16;
  // level word field base for the transmit count
  localparam int LV_TX_LSB = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BITS = 8,
  localparam int KW  = $clog2(2 * BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  input  logic            tick,
  input  logic            cpha,
  input  logic            cpol,
  input  logic            lsb_first,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic [BITS-1:0] rx_q
);
  localparam logic [KW-1:0] K_LAST = KW'(2 * BITS - 1);

  logic            active;
  logic [KW-1:0]   k;
  logic [BITS-1:0] tsh, rsh, rsh_next;
  logic            step, sample_now, shift_now;

  assign step       = active && tick;
  // phase 0 samples on even strobes, phase 1 on odd strobes
  assign sample_now = step && (k[0] == cpha);
  assign shift_now  = step && (cpha ? (!k[0] && k != '0) : (k[0] && k != K_LAST));
  assign rsh_next   = lsb_first ? {miso, rsh[BITS-1:1]} : {rsh[BITS-2:0], miso};
  assign mosi       = lsb_first ? tsh[0] : tsh[BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      k      <= '0;
      tsh    <= '0;
      rsh    <= '0;
      rx_q   <= '0;
      done   <= 1'b0;
      sck    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load && !active) begin
        active <= 1'b1;
        k      <= '0;
        tsh    <= load_byte;
        sck    <= cpol;
      end else if (active) begin
        if (step) begin
          sck <= ~sck;
          k   <= k + 1'b1;
          if (sample_now) rsh <= rsh_next;
          if (shift_now)
            tsh <= lsb_first ? {1'b0, tsh[BITS-1:1]} : {tsh[BITS-2:0], 1'b0};
          if (k == K_LAST) begin
            active <= 1'b0;
            done   <= 1'b1;
            rx_q   <= sample_now ? rsh_next : rsh;
          end
        end
      end else begin
        sck <= cpol;
      end
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int FIFO_DEPTH = 64,
  parameter int LEN_W      = 24,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [15:0]      ctrl_wdata,
  output logic [15:0]      ctrl_q,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             tc_irq_en,
  input  logic             sts_we,
  input  logic [31:0]      sts_wdata,
  output logic [31:0]      sts_q,
  output logic             irq,
  input  logic             tx_push,
  input  logic [7:0]       tx_byte,
  input  logic             rx_pop,
  output logic [7:0]       rx_byte,
  output logic [31:0]      fifo_level,
  input  logic             sck_tick,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  import spi_burst_pkg::*;

  eng_state_t       state;
  logic             en_q, mst_q, cpha_q, cpol_q, lsb_q, dhb_q, go_q, tc_q;
  logic [LEN_W-1:0] rem_q, txrem_q;
  logic             run, finish, load_go, load_fifo;
  logic [7:0]       load_val;
  logic             tx_clr, rx_clr, tx_empty, tx_full_unused, rx_empty_unused, rx_full_unused;
  logic [LVL_W-1:0] tx_cnt, rx_cnt;
  logic [7:0]       tx_head, sh_rx;
  logic             sh_done;
  logic             unused_wbits;

  assign unused_wbits = ^{ctrl_wdata[5:4], ctrl_wdata[7], ctrl_wdata[14:11],
                          sts_wdata[31:17], sts_wdata[15:0],
                          tx_full_unused, rx_empty_unused, rx_full_unused};

  assign run    = en_q && mst_q;
  assign tx_clr = ctrl_we && ctrl_wdata[CB_TXRST];
  assign rx_clr = ctrl_we && ctrl_wdata[CB_RXRST];

  // decide the next byte in the load state
  always_comb begin
    finish    = 1'b0;
    load_go   = 1'b0;
    load_fifo = 1'b0;
    load_val  = 8'h00;
    if (state == ST_LOAD && run) begin
      if (rem_q == '0) begin
        finish = 1'b1;
      end else if (txrem_q != '0) begin
        if (!tx_empty) begin
          load_go   = 1'b1;
          load_fifo = 1'b1;
          load_val  = tx_head;
        end
      end else begin
        load_go = 1'b1;
      end
    end
  end

  spi_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .din(tx_byte),
    .pop(load_fifo), .dout(tx_head),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full_unused)
  );

  spi_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(sh_done && !dhb_q), .din(sh_rx),
    .pop(rx_pop), .dout(rx_byte),
    .count(rx_cnt), .empty(rx_empty_unused), .full(rx_full_unused)
  );

  spi_byte_shifter #(.BITS(8)) shifter_i (
    .clk(clk), .rst(rst),
    .load(load_go), .load_byte(load_val),
    .tick(sck_tick && run),
    .cpha(cpha_q), .cpol(cpol_q), .lsb_first(lsb_q),
    .miso(miso), .sck(sck), .mosi(mosi),
    .done(sh_done), .rx_q(sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      lsb_q   <= 1'b0;
      dhb_q   <= 1'b0;
      go_q    <= 1'b0;
      tc_q    <= 1'b0;
      rem_q   <= '0;
      txrem_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= tc_q && tc_irq_en;

      case (state)
        ST_LOAD: begin
          if (finish) begin
            go_q  <= 1'b0;
            state <= ST_IDLE;
          end else if (load_go) begin
            if (load_fifo) txrem_q <= txrem_q - 1'b1;
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sh_done) begin
            rem_q <= rem_q - 1'b1;
            state <= ST_LOAD;
          end
        end
        default: ;
      endcase

      if (ctrl_we) begin
        en_q   <= ctrl_wdata[CB_EN];
        mst_q  <= ctrl_wdata[CB_MST];
        cpha_q <= ctrl_wdata[CB_CPHA];
        cpol_q <= ctrl_wdata[CB_CPOL];
        lsb_q  <= ctrl_wdata[CB_LSB];
        dhb_q  <= ctrl_wdata[CB_DROP];
        // a go request is taken only when idle
        if (ctrl_wdata[CB_GO] && !go_q) begin
          go_q    <= 1'b1;
          rem_q   <= burst_len;
          txrem_q <= tx_len;
          state   <= ST_LOAD;
        end
      end

      // completion wins over a same-cycle clear
      if (sts_we && sts_wdata[SB_DONE]) tc_q <= 1'b0;
      if (finish) tc_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_q           = '0;
    ctrl_q[CB_EN]    = en_q;
    ctrl_q[CB_MST]   = mst_q;
    ctrl_q[CB_CPHA]  = cpha_q;
    ctrl_q[CB_CPOL]  = cpol_q;
    ctrl_q[CB_LSB]   = lsb_q;
    ctrl_q[CB_GO]    = go_q;
    ctrl_q[CB_DROP]  = dhb_q;
    sts_q            = '0;
    sts_q[SB_DONE]   = tc_q;
    fifo_level       = '0;
    fifo_level[LVL_W-1:0]           = rx_cnt;
    fifo_level[LV_TX_LSB +: LVL_W]  = tx_cnt;
  end
endmodule

module spi_burst_engine_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      go_q,
  input logic                      tc_q,
  input spi_burst_pkg::eng_state_t state,
  input logic                      sck,
  input logic                      cpol_q,
  input logic                      en_q,
  input logic                      mst_q,
  input logic                      dhb_q,
  input logic [CW-1:0]             tx_cnt,
  input logic [CW-1:0]             rx_cnt,
  input logic                      irq,
  input logic                      tc_irq_en
);
  import spi_burst_pkg::*;

  assert_go_fall_flags_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> tc_q);

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SHIFT && $past(state) != ST_SHIFT) |-> (sck == $past(cpol_q)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  assert_discard_keeps_rx_R6: assert property (@(posedge clk) disable iff (rst)
    $past(dhb_q) |-> (rx_cnt <= $past(rx_cnt)));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tc_q && tc_irq_en));

  assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !(en_q && mst_q)) |=> $stable(sck));
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.DEPTH(FIFO_DEPTH), .CW(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .go_q(go_q), .tc_q(tc_q), .state(state),
  .sck(sck), .cpol_q(cpol_q), .en_q(en_q), .mst_q(mst_q), .dhb_q(dhb_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .irq(irq), .tc_irq_en(tc_irq_en)
);

// File: tb/spi_burst_engine_tb.sv
`timescale 1ns/1ps
module spi_burst_engine_tb_top;
  localparam int EN = 16'h0001, MST = 16'h0002, CPHA = 16'h0004, CPOL = 16'h0008;
  localparam int LSB = 16'h0040, TXR = 16'h0100, RXR = 16'h0200, GO = 16'h0400, DROP = 16'h8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_q;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic tc_irq_en = 1'b0;
  logic sts_we = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic [31:0] sts_q, fifo_level;
  logic irq, tx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_byte = '0, rx_byte;
  logic sck_tick = 1'b0, sck, mosi, miso;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign miso = ~mosi;

  spi_burst_engine dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .burst_len(burst_len), .tx_len(tx_len), .tc_irq_en(tc_irq_en),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_q(sts_q), .irq(irq),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
    .fifo_level(fifo_level), .sck_tick(sck_tick), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // half-period strobe every third cycle
  logic [1:0] tdiv = '0;
  always @(posedge clk) begin
    tdiv     <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    sck_tick <= (tdiv == 2'd2);
  end

  // wire monitor acting as a slave receiver
  logic m_cpol = 1'b0, m_cpha = 1'b0, mon_on = 1'b0;
  logic [7:0] cap = '0;
  int mon_bits = 0, mon_n = 0, edges = 0;
  logic [7:0] mon_bytes [128];
  always @(sck) begin
    if (mon_on && !rst) begin
      edges = edges + 1;
      if ((sck != m_cpol) == !m_cpha) begin
        cap = {cap[6:0], mosi};
        mon_bits = mon_bits + 1;
        if (mon_bits == 8) begin
          if (mon_n < 128) mon_bytes[mon_n] = cap;
          mon_n = mon_n + 1;
          mon_bits = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FIFO FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s + i * 37) ^ (i << 3));
  endfunction

  function automatic logic [7:0] rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7 - i];
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic clr_done();
    @(negedge clk);
    sts_we = 1'b1; sts_wdata = 32'h0001_0000;
    @(negedge clk);
    sts_we = 1'b0; sts_wdata = '0;
  endtask

  task automatic push_bytes(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_push = 1'b1; tx_byte = pat(s, i);
    end
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic mon_arm(input logic [15:0] mode);
    m_cpol = mode[3]; m_cpha = mode[2];
    cyc(3);
    mon_on = 1'b1; mon_bits = 0; mon_n = 0; edges = 0; cap = '0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (ctrl_q[10] && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(!ctrl_q[10], req, ctrl_q[10], 0);
    cyc(3);
  endtask

  // one full exchange with checks on wire, receive FIFO and flag
  task automatic t_burst(input logic [15:0] mode, input int total, input int txn, input int s);
    logic [7:0] exp_tx;
    wr_ctrl(mode | TXR | RXR);
    clr_done();
    mon_arm(mode);
    push_bytes(s, txn);
    burst_len = 24'(total); tx_len = 24'(txn);
    wr_ctrl(mode | GO);
    wait_idle("R2");
    chk(sts_q[16] == 1'b1, "R2", sts_q[16], 1);
    chk(mon_n == total, "R3", mon_n, total);
    for (int i = 0; i < total && i < 128; i++) begin
      exp_tx = (i < txn) ? pat(s, i) : 8'h00;
      chk(mon_bytes[i] == (mode[6] ? rev(exp_tx) : exp_tx),
          mode[6] ? "R5" : "R4", mon_bytes[i], mode[6] ? rev(exp_tx) : exp_tx);
    end
    chk(sck == mode[3], "R4", sck, mode[3]);
    if (mode[15]) begin
      chk(fifo_level[6:0] == 7'd0, "R6", fifo_level[6:0], 0);
    end else begin
      chk(fifo_level[6:0] == 7'(total), "R6", fifo_level[6:0], total);
      for (int i = 0; i < total; i++) begin
        exp_tx = (i < txn) ? pat(s, i) : 8'h00;
        chk(rx_byte == ~exp_tx, "R6", rx_byte, ~exp_tx);
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
      end
    end
    chk(fifo_level[22:16] == 7'd0, "R3", fifo_level[22:16], 0);
    mon_on = 1'b0;
    clr_done();
    chk(sts_q[16] == 1'b0, "R9", sts_q[16], 0);
  endtask

  task automatic t_reset();
    chk(fifo_level == 32'd0, "R1", fifo_level, 0);
    chk(ctrl_q == 16'd0, "R1", ctrl_q, 0);
    chk(sts_q == 32'd0, "R1", sts_q, 0);
    chk(irq == 1'b0, "R1", irq, 0);
    chk(sck == 1'b0, "R1", sck, 0);
  endtask

  task automatic t_stall();
    logic [15:0] m = EN | MST;
    wr_ctrl(m | TXR | RXR);
    mon_arm(m);
    burst_len = 24'd2; tx_len = 24'd2;
    wr_ctrl(m | GO);
    cyc(200);
    chk(ctrl_q[10] == 1'b1, "R11", ctrl_q[10], 1);
    chk(edges == 0, "R11", edges, 0);
    push_bytes(8'h5a, 2);
    wait_idle("R11");
    chk(mon_n == 2, "R11", mon_n, 2);
    chk(mon_bytes[1] == pat(8'h5a, 1), "R11", mon_bytes[1], pat(8'h5a, 1));
    mon_on = 1'b0;
    clr_done();
  endtask

  task automatic t_enable();
    wr_ctrl(MST | TXR | RXR);
    mon_arm(MST);
    burst_len = 24'd1; tx_len = 24'd0;
    wr_ctrl(MST | GO);
    cyc(150);
    chk(edges == 0, "R10", edges, 0);
    chk(ctrl_q[10] == 1'b1, "R10", ctrl_q[10], 1);
    wr_ctrl(EN | MST);
    wait_idle("R10");
    chk(mon_n == 1, "R10", mon_n, 1);
    mon_on = 1'b0;
    clr_done();
  endtask

  task automatic t_zero();
    wr_ctrl(EN | MST | TXR | RXR);
    mon_arm(EN | MST);
    burst_len = 24'd0; tx_len = 24'd0;
    wr_ctrl(EN | MST | GO);
    wait_idle("R12");
    chk(edges == 0, "R12", edges, 0);
    chk(sts_q[16] == 1'b1, "R12", sts_q[16], 1);
    mon_on = 1'b0;
  endtask

  task automatic t_busy_go();
    logic [15:0] m = EN | MST;
    wr_ctrl(m | TXR | RXR);
    clr_done();
    mon_arm(m);
    push_bytes(8'h11, 3);
    burst_len = 24'd3; tx_len = 24'd3;
    wr_ctrl(m | GO);
    cyc(60);
    burst_len = 24'd10; tx_len = 24'd0;
    wr_ctrl(m | GO);
    wait_idle("R2");
    chk(mon_n == 3, "R2", mon_n, 3);
    chk(fifo_level[6:0] == 7'd3, "R2", fifo_level[6:0], 3);
    mon_on = 1'b0;
    clr_done();
  endtask

  task automatic t_fifo();
    wr_ctrl(TXR | RXR);
    push_bytes(8'h20, 70);
    chk(fifo_level[22:16] == 7'd64, "R7", fifo_level[22:16], 64);
    wr_ctrl(TXR);
    chk(fifo_level[22:16] == 7'd0, "R8", fifo_level[22:16], 0);
    chk(ctrl_q[8] == 1'b0, "R8", ctrl_q[8], 0);
    burst_len = 24'd2; tx_len = 24'd0;
    wr_ctrl(EN | MST | GO);
    wait_idle("R8");
    chk(fifo_level[6:0] == 7'd2, "R8", fifo_level[6:0], 2);
    wr_ctrl(EN | MST | RXR);
    chk(fifo_level[6:0] == 7'd0, "R8", fifo_level[6:0], 0);
    clr_done();
  endtask

  task automatic t_irq();
    burst_len = 24'd0;
    wr_ctrl(EN | MST | GO);
    wait_idle("R9");
    chk(irq == 1'b0, "R9", irq, 0);
    tc_irq_en = 1'b1;
    cyc(2);
    chk(irq == 1'b1, "R9", irq, 1);
    clr_done();
    cyc(1);
    chk(irq == 1'b0, "R9", irq, 0);
    chk(sts_q[16] == 1'b0, "R9", sts_q[16], 0);
    tc_irq_en = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("WATCHDOG FAIL timeout actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_burst(EN | MST, 4, 4, 8'h31);
    t_burst(EN | MST | CPHA, 3, 3, 8'h47);
    t_burst(EN | MST | CPOL, 3, 2, 8'h93);
    t_burst(EN | MST | CPOL | CPHA | LSB, 4, 4, 8'hc6);
    t_burst(EN | MST | LSB, 3, 1, 8'h0d);
    t_burst(EN | MST | DROP, 4, 4, 8'h72);
    t_burst(EN | MST | CPHA | LSB, 5, 0, 8'h00);
    t_stall();
    t_enable();
    t_zero();
    t_busy_go();
    t_fifo();
    t_irq();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule